// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one processor-side bus transfer at a time on a bus whose lower sixteen lines carry first an address and then data, with a 20-bit address in total. The requester presents a request with these fields:

- an address
- a direction (read or write)
- an address space (memory or I/O)
- a size (byte or word)
- write data
- a two-bit segment tag

The block latches the request and steps through four clock states, T1 to T4. It drives the address-latch strobe, the read and write strobes, the space select, the direction line, the data buffer enable and the active-low upper-byte enable.

The four upper lines carry address bits 19..16 while the address is out. After that they carry status: a bit that is always zero, the live interrupt-enable flag, and the segment tag. A device can slow the transfer by holding its ready input low, and each low sample inserts a wait state between T2 and T3. Read data is taken from the bus at the end of T3 and is presented with a one-clock completion pulse in T4. A word request at an odd address is refused with a one-clock error pulse.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, busy, done, err and addr_latch are 0, and rd_strobe_n, wr_strobe_n and hi_byte_n are 1.
- R2: In T1 (the first clock after a request is accepted), addr_latch is 1, ad_oe is 1, ad_out equals address bits 15..0 and upper_out equals address bits 19..16. addr_latch is 0 in every other state.
- R3: In T2, TW, T3 and T4, upper_out is {0, intr_en, seg} with bit 3 = 0, bit 2 = intr_en and bits 1..0 = seg. The seg codes are 00 extra, 01 stack, 10 code or none, 11 data.
- R4: When ready is low at the end of T2 or of a wait state, one more wait state follows. The cycle moves to T3 on the first clock edge where ready is high, so N low samples give exactly N wait states.
- R5: During T2, the wait states and T3, rd_strobe_n is 0 for a read and wr_strobe_n is 0 for a write, and buf_en is 1. In T1 and T4 both strobes are 1 and buf_en is 0. The two strobes are never low together.
- R6: During the cycle, xmit_dir is 1 for a write and 0 for a read. In the data states of a write, ad_oe is 1 and ad_out carries the write data. A byte write places its low data byte on both lanes.
- R7: During the cycle, mem_sel is 1 for a memory access and 0 for an I/O access.
- R8: In T1, hi_byte_n is 0 for a word access or for a byte access at an odd address, and 1 for a byte access at an even address. In every other state hi_byte_n is 1.
- R9: done is 1 for exactly one clock, in T4. For a read, rdata then holds the bus value sampled at the end of T3: the full word for a word access, the low lane zero-extended for an even byte, and the high lane zero-extended for an odd byte.
- R10: A word request at an odd address starts no cycle. err is 1 for the following clock only, and busy stays 0.
- R11: busy is 1 from T1 through T4. A request presented while busy is ignored, so no second cycle follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment tag shown on status bits 1..0 |
| intr_en | input | 1 | Interrupt-enable flag shown on status bit 2 |
| ready | input | 1 | Device ready, low inserts wait states |
| ad_in | input | 16 | Bus value seen on the shared lines |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| upper_out | output | 4 | Address bits 19..16 in T1, status afterwards |
| addr_latch | output | 1 | High while the shared lines hold the address |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| mem_sel | output | 1 | 1 = memory access, 0 = I/O |
| xmit_dir | output | 1 | 1 = block transmits, 0 = block receives |
| buf_en | output | 1 | Enables external data buffers |
| hi_byte_n | output | 1 | Active-low upper-byte enable in T1, 1 elsewhere |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result |
| err | output | 1 | Odd-address word refusal pulse |

## Verification
The assertions assume that ready is a clean, settled level at each clock edge. They also assume that ad_in is stable at the edge that ends T3. No assumption is made about when requests arrive, because the block must discard any request seen while busy.

The stimulus changes every input half a clock away from the sampling edge. Ready is held low for a chosen number of samples, taken at random from 0 to 3 and with a directed run of five. The bench also raises a competing request in the middle of cycles to exercise the ignore rule.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_word,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_seg,
  input  logic          intr_en,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] upper_out,
  output logic          addr_latch,
  output logic          rd_strobe_n,
  output logic          wr_strobe_n,
  output logic          mem_sel,
  output logic          xmit_dir,
  output logic          buf_en,
  output logic          hi_byte_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          err
);
  localparam int HW = DW / 2;
  localparam int UW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4} st_t;

  st_t           st;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q, rd_q;
  logic [1:0]    seg_q;
  logic          wr_q, io_q, w_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      seg_q <= '0;
      wr_q  <= 1'b0;
      io_q  <= 1'b0;
      w_q   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_word && req_addr[0]) err_q <= 1'b1;
          else begin
            a_q   <= req_addr;
            wd_q  <= req_wdata;
            seg_q <= req_seg;
            wr_q  <= req_write;
            io_q  <= req_io;
            w_q   <= req_word;
            st    <= S_T1;
          end
        end
        S_T1: st <= S_T2;
        S_T2, S_TW: st <= ready ? S_T3 : S_TW;
        S_T3: begin
          st <= S_T4;
          if (!wr_q) begin
            if (w_q)         rd_q <= ad_in;
            else if (a_q[0]) rd_q <= {{HW{1'b0}}, ad_in[DW-1:HW]};
            else             rd_q <= {{HW{1'b0}}, ad_in[HW-1:0]};
          end
        end
        S_T4: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_t1, data_ph, act;
  logic [UW-1:0] stat;
  assign in_t1   = (st == S_T1);
  assign data_ph = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign act     = (st != S_IDLE);
  assign stat    = UW'({1'b0, intr_en, seg_q});

  assign ad_out      = in_t1 ? a_q[DW-1:0] : (w_q ? wd_q : {wd_q[HW-1:0], wd_q[HW-1:0]});
  assign ad_oe       = in_t1 || (act && wr_q);
  assign upper_out   = in_t1 ? a_q[AW-1:DW] : (act ? stat : '0);
  assign addr_latch  = in_t1;
  assign rd_strobe_n = !(data_ph && !wr_q);
  assign wr_strobe_n = !(data_ph && wr_q);
  assign buf_en      = data_ph;
  assign xmit_dir    = act ? wr_q : 1'b1;
  assign mem_sel     = act && !io_q;
  assign hi_byte_n   = in_t1 ? !(w_q || a_q[0]) : 1'b1;
  assign busy        = act;
  assign done        = (st == S_T4);
  assign rdata       = rd_q;
  assign err         = err_q;

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n));
  p_wait_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n || !wr_strobe_n) && !ready |=> (!rd_strobe_n || !wr_strobe_n));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_status_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !addr_latch |-> !upper_out[UW-1]);
  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  p_latch_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> addr_latch);
  p_hi_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_latch |-> hi_byte_n);
endmodule

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_io = 0, req_word = 0, intr_en = 0, ready = 1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic [1:0]  req_seg = '0;
  logic [15:0] ad_out, rdata;
  logic [3:0]  upper_out;
  logic ad_oe, addr_latch, rd_strobe_n, wr_strobe_n, mem_sel, xmit_dir, buf_en, hi_byte_n, busy, done, err;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_hi_n(input logic [19:0] a, input logic word);
    return !(word || a[0]);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [19:0] a, input logic word, input logic [15:0] bus);
    if (word) return bus;
    return a[0] ? {8'h00, bus[15:8]} : {8'h00, bus[7:0]};
  endfunction

  task automatic do_cycle(input logic [19:0] a, input logic w, io, word, input logic [15:0] wd,
                          input logic [1:0] sg, input logic ie, input int nw);
    logic [15:0] bus;
    bus = 16'($urandom);
    @(negedge clk);
    req_addr = a; req_write = w; req_io = io; req_word = word; req_wdata = wd; req_seg = sg;
    intr_en = ie; req_valid = 1; ready = (nw == 0); ad_in = bus;
    @(negedge clk);
    chk(addr_latch == 1 && ad_oe == 1, "R2 latch/oe in T1", {addr_latch, ad_oe}, 2'b11);
    chk(ad_out == a[15:0], "R2 low address", ad_out, a[15:0]);
    chk(upper_out == a[19:16], "R2 upper address", upper_out, a[19:16]);
    chk(hi_byte_n == exp_hi_n(a, word), "R8 upper byte enable", hi_byte_n, exp_hi_n(a, word));
    chk(busy == 1, "R11 busy in T1", busy, 1);
    chk(rd_strobe_n && wr_strobe_n && !buf_en, "R5 idle strobes in T1", {rd_strobe_n, wr_strobe_n, buf_en}, 3'b110);
    req_addr = a ^ 20'h00002; req_word = 0;
    @(negedge clk);
    chk(upper_out == {1'b0, ie, sg}, "R3 status bits", upper_out, {1'b0, ie, sg});
    chk(rd_strobe_n == w && wr_strobe_n == !w && buf_en, "R5 strobes in T2",
        {rd_strobe_n, wr_strobe_n, buf_en}, {w, !w, 1'b1});
    chk(xmit_dir == w, "R6 direction", xmit_dir, w);
    chk(mem_sel == !io, "R7 space select", mem_sel, !io);
    chk(hi_byte_n == 1 && addr_latch == 0, "R8 upper enable off after T1", {hi_byte_n, addr_latch}, 2'b10);
    if (w) chk(ad_oe && ad_out == (word ? wd : {wd[7:0], wd[7:0]}), "R6 write data",
               ad_out, word ? wd : {wd[7:0], wd[7:0]});
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      chk(!done && (rd_strobe_n == w) && (wr_strobe_n == !w), "R4 wait state held",
          {done, rd_strobe_n, wr_strobe_n}, {1'b0, w, !w});
      ready = (i == nw - 1);
    end
    @(negedge clk);
    chk(!done && buf_en && upper_out[3] == 0, "R4 T3 reached", {done, buf_en}, 2'b01);
    req_valid = 0;
    @(negedge clk);
    chk(done == 1, "R9 done in T4", done, 1);
    chk(rd_strobe_n && wr_strobe_n && !buf_en, "R5 strobes off in T4", {rd_strobe_n, wr_strobe_n, buf_en}, 3'b110);
    if (!w) chk(rdata == exp_rd(a, word, bus), "R9 read data", rdata, exp_rd(a, word, bus));
    @(negedge clk);
    chk(!busy && !done, "R11 no restart after cycle", {busy, done}, 2'b00);
    ready = 1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !addr_latch && rd_strobe_n && wr_strobe_n && hi_byte_n,
        "R1 reset state", {busy, done, err, addr_latch, rd_strobe_n, wr_strobe_n, hi_byte_n}, 7'b0000111);
    rst_n = 1;
    do_cycle(20'hA5A50, 0, 0, 1, 16'h0, 2'b11, 1, 0);
    do_cycle(20'h12345, 0, 1, 0, 16'h0, 2'b01, 0, 2);
    do_cycle(20'hFFFF4, 1, 0, 0, 16'hBEEF, 2'b00, 1, 0);
    do_cycle(20'h0F00E, 1, 1, 1, 16'hC0DE, 2'b10, 0, 5);
    @(negedge clk);
    req_addr = 20'h33333; req_word = 1; req_write = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(err == 1 && busy == 0, "R10 odd word refused", {err, busy}, 2'b10);
    @(negedge clk);
    chk(err == 0 && busy == 0, "R10 error pulse ends", {err, busy}, 2'b00);
    for (int k = 0; k < 40; k++) begin
      logic [19:0] a;
      logic wd;
      a = 20'($urandom);
      wd = 1'($urandom);
      if (wd) a[0] = 1'b0;
      do_cycle(a, 1'($urandom), 1'($urandom), wd, 16'($urandom), 2'($urandom), 1'($urandom), int'($urandom_range(0, 3)));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule